// File: doc/BRIEF.md
# Serial Control Word Loader with Destination Routing

This block accepts synthesizer configuration over a three-wire serial link made of a serial clock, a data line and a load strobe. Bits enter a 20-bit shift register most significant bit first, one bit per rising serial-clock edge. A rising load strobe copies the shift register into one of three holding latches. The last two bits shifted in choose the latch.

The three latches hold different things. The divide latch holds a 6-bit swallow count and a 6-bit main count. The reference latch holds a single 6-bit divide ratio. The function latch holds 18 bits of mode settings. A chip-enable input marks when the part is powered. On its rising edge, the divide and reference values are copied into the counter preload outputs. Software is expected to load all latches while the part is disabled, then raise chip enable.

All serial inputs and chip enable are asynchronous to the system clock. Each passes through a two-flop synchronizer, and its edges are detected in the system clock domain. A one-cycle pulse marks every divide-latch write, so lock-assist logic can start.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, every latch output, every counter preload output, `powered_up` and `new_n_loaded` are zero.
- R2: On each rising serial-clock edge, the register shifts toward its upper end and takes the data bit in at bit 0. A word is therefore sent bit 19 first. Only the last 20 bits sent before the load strobe count.
- R3: Call the word at load time w. Its control field is C1 = w[0] and C2 = w[1]. When C1=0 and C2=0, the divide latch is written: swallow = w[7:2] and main = w[13:8]. Bits w[19:14] are ignored.
- R4: When C1=0 and C2=1, the reference latch takes w[7:2]. The other payload bits are ignored, and the divide and function latches keep their contents.
- R5: When C1=1, the function latch takes w[19:2] whatever C2 is. The divide and reference latches keep their contents.
- R6: Shifting alone changes no latch. Latches change only on a rising load strobe.
- R7: `new_n_loaded` is high for exactly one system clock cycle on each divide-latch write. It stays low for reference and function writes.
- R8: A rising chip enable copies the divide latch and the reference latch into the counter preload outputs. At any other time those outputs hold their value, even when a latch is rewritten.
- R9: `powered_up` follows the synchronized chip enable. It is low while chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock; a bit is taken on its rising edge |
| ser_dat | input | 1 | Serial data, sent most significant bit first |
| ser_le | input | 1 | Load strobe; a rising edge routes the word to a latch |
| chip_en | input | 1 | Chip enable; a rising edge pushes values to the counters |
| swallow_q | output | 6 | Divide latch swallow count |
| main_q | output | 6 | Divide latch main count |
| ref_q | output | 6 | Reference latch divide ratio |
| func_q | output | 18 | Function latch contents |
| cnt_swallow | output | 6 | Swallow counter preload |
| cnt_main | output | 6 | Main counter preload |
| cnt_ref | output | 6 | Reference counter preload |
| powered_up | output | 1 | Synchronized chip enable |
| new_n_loaded | output | 1 | One-cycle pulse on each divide-latch write |

## Verification
The shift register is not visible at the ports. A dropped or extra shift, or a wrong control-bit decode, therefore stays hidden until the next load strobe. It then shows as a wrong value in exactly one of the four latch outputs, or as a write to a latch that should have kept its value. That shows about four system cycles after the strobe edge. Faults in chip-enable handling show in the preload outputs after the next chip-enable rise, or as a change at some other time. A fault in the pulse logic shows as a pulse count other than one per divide write, or a pulse on another destination.

// File: rtl/slr_pkg.sv
package slr_pkg;
   typedef enum logic [1:0] {
      DEST_DIV  = 2'd0,
      DEST_REF  = 2'd1,
      DEST_FUNC = 2'd2
   } dest_e;

   // c1 is the last bit shifted in, c2 the one before it
   function automatic dest_e route_of(input logic c1, input logic c2);
      if (c1)      return DEST_FUNC;
      else if (c2) return DEST_REF;
      else         return DEST_DIV;
   endfunction
endpackage

// File: rtl/slr_sync_rise.sv
module slr_sync_rise #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic level_o,
   output logic rise_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("slr_sync_rise needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], async_in};
         prev  <= chain[STAGES-1];
      end
   end

   assign level_o = chain[STAGES-1];
   assign rise_o  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/slr_shift.sv
module slr_shift #(
   parameter int WIDTH = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             bit_in,
   output logic [WIDTH-1:0] word_o
);
   generate
      if (WIDTH < 4) begin : g_bad_width
         $error("slr_shift width too small");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word_o <= '0;
      else if (shift_en) word_o <= {word_o[WIDTH-2:0], bit_in};
   end

   // R2
   shift_in_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> word_o[0] == $past(bit_in));

   // R2
   shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(word_o));
endmodule

// File: rtl/slr_latch_bank.sv
module slr_latch_bank
   import slr_pkg::*;
#(
   parameter int SR_W    = 20,
   parameter int CTL_W   = 2,
   parameter int FIELD_W = 6,
   localparam int FUNC_W = SR_W - CTL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [SR_W-1:0]    word,
   output logic [FIELD_W-1:0] swallow_o,
   output logic [FIELD_W-1:0] main_o,
   output logic [FIELD_W-1:0] ref_o,
   output logic [FUNC_W-1:0]  func_o,
   output logic               n_pulse_o
);
   generate
      if (CTL_W != 2) begin : g_bad_ctl
         $error("control field must be two bits");
      end
      if (SR_W < CTL_W + 2*FIELD_W) begin : g_bad_sr
         $error("shift register too short for the divide fields");
      end
   endgenerate

   localparam int A_LO = CTL_W;
   localparam int B_LO = CTL_W + FIELD_W;

   dest_e dest;
   assign dest = route_of(word[0], word[1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         swallow_o <= '0;
         main_o    <= '0;
         ref_o     <= '0;
         func_o    <= '0;
         n_pulse_o <= 1'b0;
      end else begin
         n_pulse_o <= 1'b0;
         if (load) begin
            unique case (dest)
               DEST_DIV: begin
                  swallow_o <= word[A_LO +: FIELD_W];
                  main_o    <= word[B_LO +: FIELD_W];
                  n_pulse_o <= 1'b1;
               end
               DEST_REF:  ref_o  <= word[A_LO +: FIELD_W];
               default:   func_o <= word[SR_W-1:CTL_W];
            endcase
         end
      end
   end

   // R6
   hold_without_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(swallow_o) && $stable(main_o) && $stable(ref_o) && $stable(func_o)));

   // R7
   pulse_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      n_pulse_o |-> $past(load) && $past(word[1:0]) == 2'b00);

   // R7
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      n_pulse_o |=> !n_pulse_o);

   // R5
   func_keeps_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && word[0]) |=> ($stable(swallow_o) && $stable(main_o) && $stable(ref_o)));
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
   parameter int SR_W        = 20,
   parameter int CTL_W       = 2,
   parameter int FIELD_W     = 6,
   parameter int SYNC_STAGES = 2,
   localparam int FUNC_W     = SR_W - CTL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ser_clk,
   input  logic               ser_dat,
   input  logic               ser_le,
   input  logic               chip_en,
   output logic [FIELD_W-1:0] swallow_q,
   output logic [FIELD_W-1:0] main_q,
   output logic [FIELD_W-1:0] ref_q,
   output logic [FUNC_W-1:0]  func_q,
   output logic [FIELD_W-1:0] cnt_swallow,
   output logic [FIELD_W-1:0] cnt_main,
   output logic [FIELD_W-1:0] cnt_ref,
   output logic               powered_up,
   output logic               new_n_loaded
);
   localparam int N_IN = 4;

   logic [N_IN-1:0] raw_in, lvl, rise;
   assign raw_in = {chip_en, ser_le, ser_dat, ser_clk};

   genvar gi;
   generate
      for (gi = 0; gi < N_IN; gi++) begin : g_sync
         slr_sync_rise #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (raw_in[gi]),
            .level_o  (lvl[gi]),
            .rise_o   (rise[gi])
         );
      end
   endgenerate

   logic [SR_W-1:0] sr_word;

   slr_shift #(.WIDTH(SR_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (rise[0]),
      .bit_in   (lvl[1]),
      .word_o   (sr_word)
   );

   slr_latch_bank #(.SR_W(SR_W), .CTL_W(CTL_W), .FIELD_W(FIELD_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (rise[2]),
      .word      (sr_word),
      .swallow_o (swallow_q),
      .main_o    (main_q),
      .ref_o     (ref_q),
      .func_o    (func_q),
      .n_pulse_o (new_n_loaded)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_swallow <= '0;
         cnt_main    <= '0;
         cnt_ref     <= '0;
      end else if (rise[3]) begin
         cnt_swallow <= swallow_q;
         cnt_main    <= main_q;
         cnt_ref     <= ref_q;
      end
   end

   assign powered_up = lvl[3];

   // R8
   preload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rise[3] |=> ($stable(cnt_swallow) && $stable(cnt_main) && $stable(cnt_ref)));

   // R8
   preload_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise[3] |=> (cnt_main == $past(main_q) && cnt_ref == $past(ref_q)));
endmodule

// File: tb/serial_cfg_loader_tb_top.sv
module serial_cfg_loader_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0, chip_en = 1'b0;
   logic [5:0]  swallow_q, main_q, ref_q, cnt_swallow, cnt_main, cnt_ref;
   logic [17:0] func_q;
   logic        powered_up, new_n_loaded;

   int checks = 0;
   int errors = 0;
   int pulse_hi = 0;
   logic done = 1'b0;

   always #10 clk = ~clk;

   serial_cfg_loader dut_i (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_le(ser_le), .chip_en(chip_en), .swallow_q(swallow_q),
      .main_q(main_q), .ref_q(ref_q), .func_q(func_q),
      .cnt_swallow(cnt_swallow), .cnt_main(cnt_main), .cnt_ref(cnt_ref),
      .powered_up(powered_up), .new_n_loaded(new_n_loaded)
   );

   always @(negedge clk) if (new_n_loaded) pulse_hi++;

   // {expected destination 0=div 1=ref 2=func, word}; word[1:0] = {C2,C1}
   localparam logic [21:0] VEC [8] = '{
      {2'd0, 6'h2A, 6'd9,  6'd5,  2'b00},
      {2'd1, 12'hABC,      6'd17, 2'b10},
      {2'd2, 18'h25A3C,           2'b01},
      {2'd2, 18'h10F0F,           2'b11},
      {2'd0, 6'h3F, 6'd63, 6'd0,  2'b00},
      {2'd1, 12'h000,      6'd63, 2'b10},
      {2'd0, 6'h00, 6'd3,  6'd63, 2'b00},
      {2'd2, 18'h3FFFF,           2'b01}
   };

   logic [5:0]  m_a = '0, m_b = '0, m_r = '0;
   logic [17:0] m_f = '0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_bits(input logic [19:0] w, input int nbits);
      for (int i = nbits - 1; i >= 0; i--) begin
         ser_dat = w[i];
         repeat (4) @(negedge clk);
         ser_clk = 1'b1;
         repeat (4) @(negedge clk);
         ser_clk = 1'b0;
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic strobe();
      pulse_hi = 0;
      ser_le = 1'b1;
      repeat (4) @(negedge clk);
      ser_le = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic model_load(input logic [19:0] w);
      if (w[0])      m_f = w[19:2];
      else if (w[1]) m_r = w[7:2];
      else begin
         m_a = w[7:2];
         m_b = w[13:8];
      end
   endtask

   task automatic check_latches(input string req);
      chk({req, " swallow"}, 32'(swallow_q), 32'(m_a));
      chk({req, " main"},    32'(main_q),    32'(m_b));
      chk({req, " ref"},     32'(ref_q),     32'(m_r));
      chk({req, " func"},    32'(func_q),    32'(m_f));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 swallow", 32'(swallow_q), 0);
      chk("R1 main", 32'(main_q), 0);
      chk("R1 ref", 32'(ref_q), 0);
      chk("R1 func", 32'(func_q), 0);
      chk("R1 cnt", 32'({cnt_swallow, cnt_main, cnt_ref}), 0);
      chk("R1 powered_up", 32'(powered_up), 0);
      chk("R1 pulse", 32'(new_n_loaded), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // Vector walk: R3 R4 R5 R7
      for (int v = 0; v < 8; v++) begin
         send_bits(VEC[v][19:0], 20);
         strobe();
         model_load(VEC[v][19:0]);
         check_latches("R3/R4/R5 vector");
         chk("R7 pulse count", pulse_hi, (VEC[v][21:20] == 2'd0) ? 1 : 0);
      end

      // R6: shifting without a strobe changes nothing
      send_bits({6'h15, 6'd44, 6'd33, 2'b00}, 20);
      check_latches("R6 no strobe");
      chk("R6 no pulse", pulse_hi, 0);

      // R2: extra leading bits fall off, only last 20 count
      send_bits(20'hFFFFF, 4);
      send_bits({6'h00, 6'd21, 6'd42, 2'b00}, 20);
      strobe();
      model_load({6'h00, 6'd21, 6'd42, 2'b00});
      check_latches("R2 overflow");

      // R8: no chip-enable rise yet, preloads still zero
      chk("R8 cnt before ce", 32'({cnt_swallow, cnt_main, cnt_ref}), 0);
      chk("R9 off", 32'(powered_up), 0);
      chip_en = 1'b1;
      repeat (8) @(negedge clk);
      chk("R9 on", 32'(powered_up), 1);
      chk("R8 cnt_swallow", 32'(cnt_swallow), 32'(m_a));
      chk("R8 cnt_main", 32'(cnt_main), 32'(m_b));
      chk("R8 cnt_ref", 32'(cnt_ref), 32'(m_r));

      // R8: rewrite while enabled, preloads hold
      send_bits({6'h00, 6'd7, 6'd11, 2'b00}, 20);
      strobe();
      send_bits({12'h000, 6'd29, 2'b10}, 20);
      strobe();
      chk("R8 hold main", 32'(cnt_main), 32'(m_b));
      chk("R8 hold ref", 32'(cnt_ref), 32'(m_r));
      model_load({6'h00, 6'd7, 6'd11, 2'b00});
      model_load({12'h000, 6'd29, 2'b10});
      check_latches("R3/R4 while enabled");

      chip_en = 1'b0;
      repeat (8) @(negedge clk);
      chk("R9 off again", 32'(powered_up), 0);
      chip_en = 1'b1;
      repeat (8) @(negedge clk);
      chk("R8 second swallow", 32'(cnt_swallow), 32'd11);
      chk("R8 second main", 32'(cnt_main), 32'd7);
      chk("R8 second ref", 32'(cnt_ref), 32'd29);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule